// File: doc/BRIEF.md
# Set/Clear Pin Bank

A 32-pin general-purpose I/O bank that sits on a simple register port made of a write strobe, a read strobe, a byte offset and a 32-bit data word. Software never rewrites a whole data register to change one pin. Instead, each pin's output level and each pin's driver enable can be raised or lowered bit by bit. A dedicated offset raises bits and a separate offset lowers them. Bits written as zero are left alone, so two agents can change different pins without a read-modify-write race.

Each pin presents an output level, an output enable and an input level towards its pad. The input levels are brought into the clock domain through a two-flop synchroniser before they can be read back. Bit n of every data word always belongs to pin n.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, every output level bit and every driver enable bit is 0, and the read data word is 0.
- R2: A write to offset 0x00 drives the output level of pin n to 1 for each data bit n that is 1. The other pins keep their level. The new level is on the pad outputs after the clock edge that takes the write.
- R3: A write to offset 0x10 drives the output level of pin n to 0 for each data bit n that is 1. The other pins keep their level.
- R4: A write to offset 0x20 switches on the driver of pin n for each data bit n that is 1. The other drivers are unchanged.
- R5: A write to offset 0x30 switches off the driver of pin n (tristate) for each data bit n that is 1. The other drivers are unchanged.
- R6: A read of offset 0x40 returns the pin input levels, with bit n holding pin n. These levels pass through two synchronising flops first, so a pin change that falls before clock edge k shows in a read taken at edge k+2 and not earlier.
- R7: A read of offset 0x00 or 0x10 returns the output level register. A read of 0x20 or 0x30 returns the driver enable register.
- R8: Any offset other than 0x00, 0x10, 0x20, 0x30 and 0x40 is unmapped. A write to it changes nothing, and a read of it returns 0.
- R9: The read data is registered. It is loaded at the clock edge where the read strobe is high and holds its value at every other edge. A read that shares an edge with a write returns the value from before that write.
- R10: While the write strobe is low, the output levels and driver enables do not change, whatever the offset and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, taken at the rising edge |
| rdEn | input | 1 | Read strobe, taken at the rising edge |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data, bit n for pin n |
| rdData | output | 32 | Registered read data |
| padOut | output | 32 | Output level for each pin |
| padOe | output | 32 | Driver enable for each pin, 1 drives |
| padIn | input | 32 | Pin input level from each pad |

## Verification
Write results reach padOut and padOe one clock edge after the strobe. A read result reaches rdData at the same single edge. A pin change needs two more edges on top of that before a read can see it. The bench drives every stimulus on the falling edge, which places each strobe on exactly one rising edge. It samples on the next falling edge, after the register has taken the value. In the synchroniser scenario, rdEn stays high across three successive edges. The bench expects the old pin value after the first two edges and the new value only after the third.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Byte offsets of the register port; the offsets are fixed by the software map
  localparam int OFS_OUT_SET = 'h00;
  localparam int OFS_OUT_CLR = 'h10;
  localparam int OFS_OE_SET  = 'h20;
  localparam int OFS_OE_CLR  = 'h30;
  localparam int OFS_PIN_LVL = 'h40;

  // Source picked for the read data register
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_OUT  = 2'd1,
    RD_OE   = 2'd2,
    RD_PIN  = 2'd3
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   setOut;
    logic   clrOut;
    logic   setOe;
    logic   clrOe;
    logic   rdStb;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       cmd
);

  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFS_OUT_SET);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFS_OUT_CLR);
  localparam logic [ADDR_W-1:0] A_OE_SET  = ADDR_W'(OFS_OE_SET);
  localparam logic [ADDR_W-1:0] A_OE_CLR  = ADDR_W'(OFS_OE_CLR);
  localparam logic [ADDR_W-1:0] A_PIN_LVL = ADDR_W'(OFS_PIN_LVL);

  always_comb begin
    cmd        = '0;
    cmd.rdStb  = rdEn;
    cmd.rdSel  = RD_ZERO;
    if (wrEn) begin
      case (addr)
        A_OUT_SET: cmd.setOut = 1'b1;
        A_OUT_CLR: cmd.clrOut = 1'b1;
        A_OE_SET:  cmd.setOe  = 1'b1;
        A_OE_CLR:  cmd.clrOe  = 1'b1;
        default:   ;
      endcase
    end
    case (addr)
      A_OUT_SET, A_OUT_CLR: cmd.rdSel = RD_OUT;
      A_OE_SET,  A_OE_CLR:  cmd.rdSel = RD_OE;
      A_PIN_LVL:            cmd.rdSel = RD_PIN;
      default:              cmd.rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      cmd,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] rdData
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] outLatch;
  logic [WIDTH-1:0] oeLatch;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] rdNext;

  // Output level register: set and clear are separate strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
    end else if (cmd.setOut) begin
      outLatch <= outLatch | wrData;
    end else if (cmd.clrOut) begin
      outLatch <= outLatch & ~wrData;
    end
  end

  // Driver enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeLatch <= '0;
    end else if (cmd.setOe) begin
      oeLatch <= oeLatch | wrData;
    end else if (cmd.clrOe) begin
      oeLatch <= oeLatch & ~wrData;
    end
  end

  // Input synchroniser chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= padIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  // Read source select
  always_comb begin
    unique case (cmd.rdSel)
      RD_OUT:  rdNext = outLatch;
      RD_OE:   rdNext = oeLatch;
      RD_PIN:  rdNext = syncQ[LAST_STAGE];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (cmd.rdStb) rdData <= rdNext;
  end

  assign padOut = outLatch;
  assign padOe  = oeLatch;

  AST_SET_OUT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setOut |=> ((padOut & $past(wrData)) == $past(wrData))); // R2
  AST_SET_OUT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setOut |=> ((padOut & ~$past(wrData)) == ($past(padOut) & ~$past(wrData)))); // R2
  AST_CLR_OUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrOut |=> ((padOut & $past(wrData)) == '0)); // R3
  AST_OE_ON: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setOe |=> ((padOe & $past(wrData)) == $past(wrData))); // R4
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrOe |=> ((padOe & $past(wrData)) == '0)); // R5
  AST_OUT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.setOut || cmd.clrOut) |=> $stable(padOut)); // R10
  AST_OE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.setOe || cmd.clrOe) |=> $stable(padOe)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdStb |=> $stable(rdData)); // R9
  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdStb && cmd.rdSel == RD_ZERO) |=> (rdData == '0)); // R8

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  input  logic [WIDTH-1:0]  padIn
);

  ctlStrobes_t cmd;

  gpio_port_ctl #(
    .ADDR_W(ADDR_W)
  ) u_ctl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .cmd  (cmd)
  );

  gpio_port_dp #(
    .WIDTH      (WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wrData (wrData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .rdData (rdData)
  );

endmodule

// File: tb/gpio_setclr_port_test.sv
`timescale 1ns/1ps
module gpio_setclr_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic [31:0] padIn = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_setclr_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padOut(padOut), .padOe(padOe),
    .padIn(padIn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic testReset();
    check("R1 out", padOut, 32'h0);
    check("R1 oe", padOe, 32'h0);
    check("R1 rd", rdData, 32'h0);
  endtask

  task automatic testOutSetClr();
    doWrite(8'h00, 32'hF0F0_0001);
    check("R2 set", padOut, 32'hF0F0_0001);
    doWrite(8'h00, 32'h0000_0F00);
    check("R2 keep", padOut, 32'hF0F0_0F01);
    doWrite(8'h10, 32'h8000_0101);
    check("R3 clr", padOut, 32'h70F0_0E00);
    doWrite(8'h10, 32'h0);
    check("R3 zero data", padOut, 32'h70F0_0E00);
    check("R2 oe untouched", padOe, 32'h0);
  endtask

  task automatic testOe();
    doWrite(8'h20, 32'h0000_FFFF);
    check("R4 on", padOe, 32'h0000_FFFF);
    doWrite(8'h20, 32'h8000_0000);
    check("R4 keep", padOe, 32'h8000_FFFF);
    doWrite(8'h30, 32'h0000_00F1);
    check("R5 off", padOe, 32'h8000_FF0E);
    check("R5 out untouched", padOut, 32'h70F0_0E00);
  endtask

  task automatic testReadback();
    logic [31:0] v;
    doRead(8'h00, v); check("R7 rd 0x00", v, 32'h70F0_0E00);
    doRead(8'h10, v); check("R7 rd 0x10", v, 32'h70F0_0E00);
    doRead(8'h20, v); check("R7 rd 0x20", v, 32'h8000_FF0E);
    doRead(8'h30, v); check("R7 rd 0x30", v, 32'h8000_FF0E);
  endtask

  task automatic testPinSync();
    logic [31:0] v;
    // Pin change and read strobe land before the same edge
    @(negedge clk);
    padIn = 32'hA5C3_0F81; rdEn = 1'b1; addr = 8'h40;
    @(negedge clk); check("R6 sync edge1", rdData, 32'h0);
    @(negedge clk); check("R6 sync edge2", rdData, 32'h0);
    @(negedge clk); check("R6 sync edge3", rdData, 32'hA5C3_0F81);
    rdEn = 1'b0;
    padIn = 32'h0000_0001;
    repeat (3) @(negedge clk);
    doRead(8'h40, v); check("R6 bit0 is pin0", v, 32'h0000_0001);
    padIn = 32'h8000_0000;
    repeat (3) @(negedge clk);
    doRead(8'h40, v); check("R6 bit31 is pin31", v, 32'h8000_0000);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    doWrite(8'h04, 32'hFFFF_FFFF);
    doWrite(8'h50, 32'hFFFF_FFFF);
    doWrite(8'h14, 32'hFFFF_FFFF);
    doWrite(8'h40, 32'hFFFF_FFFF);
    check("R8 out unchanged", padOut, 32'h70F0_0E00);
    check("R8 oe unchanged", padOe, 32'h8000_FF0E);
    doRead(8'h04, v); check("R8 rd 0x04", v, 32'h0);
    doRead(8'h00, v);
    doRead(8'h44, v); check("R8 rd 0x44", v, 32'h0);
    doRead(8'hFC, v); check("R8 rd 0xFC", v, 32'h0);
  endtask

  task automatic testReadTiming();
    logic [31:0] v;
    doRead(8'h20, v);
    check("R9 loaded", v, 32'h8000_FF0E);
    @(negedge clk);
    addr = 8'h00; padIn = 32'h1234_5678;
    repeat (4) @(negedge clk);
    check("R9 hold", rdData, 32'h8000_FF0E);
    // Read and write at the same edge
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 8'h00; wrData = 32'h0000_000F;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    check("R9 old value", rdData, 32'h70F0_0E00);
    check("R9 write done", padOut, 32'h70F0_0E0F);
  endtask

  task automatic testIdleWrite();
    @(negedge clk);
    addr = 8'h10; wrData = 32'hFFFF_FFFF;
    @(negedge clk);
    addr = 8'h20;
    @(negedge clk);
    addr = 8'h30;
    @(negedge clk);
    wrData = '0;
    check("R10 out", padOut, 32'h70F0_0E0F);
    check("R10 oe", padOe, 32'h8000_FF0E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOutSetClr();
    testOe();
    testReadback();
    testPinSync();
    testUnmapped();
    testReadTiming();
    testIdleWrite();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule